// File: doc/BRIEF.md
# CBR Refresh Scheduler with Power-Up Initialization

This block owns refresh timing for an asynchronous DRAM that keeps its own internal row counter. After reset is released it holds off all refresh and host traffic for a fixed power-up pause. It then runs a fixed number of CAS-before-RAS (CBR) initialization cycles and raises `init_done_o`. From then on an interval timer adds one owed refresh every `INTERVAL_CYC` clocks. The period is chosen so that all rows are covered within the retention time, which is about one refresh every 15.6 µs for 2048 rows in 32 ms.

While the access controller holds a page open, owed refreshes build up in a saturating counter. Once the count reaches `FORCE_AT`, `force_close_o` tells the controller to close its page at the next opportunity. To take the bus, the scheduler raises `ref_req_o` and waits for `ref_gnt_i`, which the controller gives only with its row closed. The scheduler then drives the RAS/CAS/WE strobes itself. No address is involved and the data pins are never driven. Host requests are refused until initialization completes and while a refresh owns the bus.

All timings are expressed in clock cycles. The defaults assume a 125 MHz clock and the 60 ns speed grade: CAS setup before RAS is 1 cycle, CAS hold after RAS fall is 2 cycles, RAS low time is 8 cycles and precharge is 5 cycles.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While reset is asserted, `ras_n_o`, `cas_n_o` and `we_n_o` are 1, and `init_done_o`, `ref_req_o`, `bus_own_o`, `host_ok_o` and `owed_o` are 0.
- R2: For the first `PAUSE_CYC` clock edges after reset release, `ref_req_o` stays 0. With `ref_gnt_i` held at 1, `cas_n_o` first goes low right after edge `PAUSE_CYC`+1.
- R3: Exactly `INIT_CBR` CBR cycles (RAS falls) take place before `init_done_o` rises, and `init_done_o` stays 1 afterwards.
- R4: In every CBR cycle, `cas_n_o` is low for exactly `CSR_CYC` cycles before `ras_n_o` falls and for exactly `CHR_CYC` cycles after it. `ras_n_o` is low for exactly `RAS_CYC` cycles, and `we_n_o` is 1 whenever `ras_n_o` is 0.
- R5: Between two consecutive CBR cycles, `ras_n_o` stays high for at least `RP_CYC`+`CSR_CYC` cycles.
- R6: Once `init_done_o` is 1, `owed_o` grows by one every `INTERVAL_CYC` clocks while no refresh completes.
- R7: `owed_o` saturates at `OWED_MAX` and never exceeds it.
- R8: `force_close_o` is 1 exactly when `init_done_o` is 1 and `owed_o` ≥ `FORCE_AT`.
- R9: Strobes go active only while `bus_own_o` is 1. `bus_own_o` rises only on the clock after a cycle in which `ref_req_o` and `ref_gnt_i` were both 1. With `ref_gnt_i` at 0, the strobes stay high.
- R10: `host_ok_o` equals `host_req_i` when `init_done_o` is 1 and `bus_own_o` is 0. Otherwise it is 0.
- R11: After initialization, each completed CBR cycle lowers `owed_o` by one, so a granted bus drains `owed_o` to 0. `owed_o` never moves by more than one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_gnt_i | input | 1 | Access controller yields the bus; its row is closed |
| host_req_i | input | 1 | Host asks to start an access |
| ref_req_o | output | 1 | Scheduler wants the bus for a refresh |
| force_close_o | output | 1 | Owed refreshes reached the threshold; close the page |
| bus_own_o | output | 1 | Scheduler is driving the DRAM strobes |
| init_done_o | output | 1 | Power-up pause and init refreshes are complete |
| host_ok_o | output | 1 | Host request accepted |
| owed_o | output | $clog2(OWED_MAX+1) | Number of refreshes currently owed |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, held high |

## Verification
The bench holds the grant low across 0 to 9 refresh intervals and reads the owed count at the exact edge of each tick. An off-by-one interval timer would show the wrong count, and a counter that wraps would read low once it passes `OWED_MAX`. A waveform monitor times every CBR: CAS setup, CAS hold, RAS width and precharge. A sequencer that drops RAS together with CAS, or that releases CAS too early, would break those cycle counts. The bench also checks the cycle of the very first CAS fall after the pause, the exact number of initialization cycles, and that hosts are refused both before `init_done_o` and while a refresh owns the bus.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_SETUP, SQ_ACTIVE, SQ_PRECH} sq_state_e;
  typedef enum logic [1:0] {PH_PAUSE, PH_INIT, PH_RUN} phase_e;
endpackage

// File: rtl/cbr_interval_timer.sv
module cbr_interval_timer #(
  parameter int PERIOD = 1950
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/cbr_owed_ctr.sv
module cbr_owed_ctr #(
  parameter int OWED_MAX = 7
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            inc_i,
  input  logic                            dec_i,
  output logic [$clog2(OWED_MAX+1)-1:0]   count_o
);
  localparam int OW = $clog2(OWED_MAX + 1);
  localparam logic [OW-1:0] CAP = OW'(OWED_MAX);

  logic [OW-1:0] cnt_q;
  logic          dec_ok;

  assign dec_ok = dec_i && (cnt_q != '0);

  // simultaneous inc and dec cancel, so a full counter stays full
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      case ({inc_i, dec_ok})
        2'b10:   if (cnt_q != CAP) cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/cbr_strobe_seq.sv
module cbr_strobe_seq
  import cbr_refresh_pkg::*;
#(
  parameter int CSR_CYC = 1,
  parameter int CHR_CYC = 2,
  parameter int RAS_CYC = 8,
  parameter int RP_CYC  = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int MAX_A = (CSR_CYC > RAS_CYC) ? CSR_CYC : RAS_CYC;
  localparam int MAX_C = (MAX_A > RP_CYC) ? MAX_A : RP_CYC;
  localparam int CW    = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] CSR_LAST = CW'(CSR_CYC - 1);
  localparam logic [CW-1:0] RAS_LAST = CW'(RAS_CYC - 1);
  localparam logic [CW-1:0] RP_LAST  = CW'(RP_CYC - 1);
  localparam logic [CW-1:0] CHR_LEN  = CW'(CHR_CYC);

  sq_state_e     st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: if (start_i) begin
          st_q  <= SQ_SETUP;
          cnt_q <= '0;
        end
        SQ_SETUP: if (cnt_q == CSR_LAST) begin
          st_q  <= SQ_ACTIVE;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        SQ_ACTIVE: if (cnt_q == RAS_LAST) begin
          st_q  <= SQ_PRECH;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        SQ_PRECH: if (cnt_q == RP_LAST) begin
          st_q  <= SQ_IDLE;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        default: begin
          st_q  <= SQ_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign busy_o  = (st_q != SQ_IDLE);
  assign done_o  = (st_q == SQ_PRECH) && (cnt_q == RP_LAST);
  assign ras_n_o = (st_q != SQ_ACTIVE);
  // CAS leads RAS in setup, then holds CHR cycles into the active phase
  assign cas_n_o = !((st_q == SQ_SETUP) || ((st_q == SQ_ACTIVE) && (cnt_q < CHR_LEN)));
endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
  import cbr_refresh_pkg::*;
#(
  parameter int PAUSE_CYC    = 25000,
  parameter int INIT_CBR     = 8,
  parameter int INTERVAL_CYC = 1950,
  parameter int OWED_MAX     = 7,
  parameter int FORCE_AT     = 4,
  parameter int CSR_CYC      = 1,
  parameter int CHR_CYC      = 2,
  parameter int RAS_CYC      = 8,
  parameter int RP_CYC       = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          ref_gnt_i,
  input  logic                          host_req_i,
  output logic                          ref_req_o,
  output logic                          force_close_o,
  output logic                          bus_own_o,
  output logic                          init_done_o,
  output logic                          host_ok_o,
  output logic [$clog2(OWED_MAX+1)-1:0] owed_o,
  output logic                          ras_n_o,
  output logic                          cas_n_o,
  output logic                          we_n_o
);
  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int IW = $clog2(INIT_CBR + 1);
  localparam int OW = $clog2(OWED_MAX + 1);
  localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYC - 1);
  localparam logic [IW-1:0] INIT_N     = IW'(INIT_CBR);
  localparam logic [OW-1:0] FORCE_LVL  = OW'(FORCE_AT);

  phase_e        phase_q;
  logic [PW-1:0] pause_q;
  logic [IW-1:0] init_left_q;
  logic          seq_busy, seq_done, seq_start, tick, want;
  logic [OW-1:0] owed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_PAUSE;
      pause_q     <= '0;
      init_left_q <= INIT_N;
    end else begin
      case (phase_q)
        PH_PAUSE: if (pause_q == PAUSE_LAST) phase_q <= PH_INIT;
                  else pause_q <= pause_q + 1'b1;
        PH_INIT:  if (seq_done) begin
          init_left_q <= init_left_q - 1'b1;
          if (init_left_q == IW'(1)) phase_q <= PH_RUN;
        end
        default:  phase_q <= PH_RUN;
      endcase
    end
  end

  cbr_interval_timer #(.PERIOD(INTERVAL_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (phase_q == PH_RUN),
    .tick_o (tick)
  );

  cbr_owed_ctr #(.OWED_MAX(OWED_MAX)) u_owed (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (tick),
    .dec_i   (seq_done && (phase_q == PH_RUN)),
    .count_o (owed)
  );

  cbr_strobe_seq #(
    .CSR_CYC (CSR_CYC),
    .CHR_CYC (CHR_CYC),
    .RAS_CYC (RAS_CYC),
    .RP_CYC  (RP_CYC)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (seq_start),
    .busy_o  (seq_busy),
    .done_o  (seq_done),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o)
  );

  assign want          = (phase_q == PH_INIT) || ((phase_q == PH_RUN) && (owed != '0));
  assign ref_req_o     = want && !seq_busy;
  assign seq_start     = ref_req_o && ref_gnt_i;
  assign bus_own_o     = seq_busy;
  assign init_done_o   = (phase_q == PH_RUN);
  assign force_close_o = init_done_o && (owed >= FORCE_LVL);
  assign host_ok_o     = host_req_i && init_done_o && !seq_busy;
  assign owed_o        = owed;
  assign we_n_o        = 1'b1;
endmodule

// File: rtl/cbr_refresh_sched_chk.sv
module cbr_refresh_sched_chk #(
  parameter int OWED_MAX = 7,
  parameter int FORCE_AT = 4
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          ref_gnt_i,
  input logic                          ref_req_o,
  input logic                          force_close_o,
  input logic                          bus_own_o,
  input logic                          init_done_o,
  input logic                          host_ok_o,
  input logic [$clog2(OWED_MAX+1)-1:0] owed_o,
  input logic                          ras_n_o,
  input logic                          cas_n_o,
  input logic                          we_n_o
);
  a_r4_cas_leads_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o)));

  a_r4_we_high_in_cbr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |-> we_n_o);

  a_r9_strobes_owned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o || !cas_n_o) |-> bus_own_o);

  a_r9_own_after_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_own_o) |-> $past(ref_req_o && ref_gnt_i));

  a_r3_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  a_r7_owed_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(owed_o) <= OWED_MAX);

  a_r8_force_after_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_close_o |-> (init_done_o && int'(owed_o) >= FORCE_AT));

  a_r10_host_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ok_o |-> (init_done_o && !bus_own_o));

  a_r11_owed_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owed_o != $past(owed_o)) |->
      ((int'(owed_o) == int'($past(owed_o)) + 1) || (int'(owed_o) + 1 == int'($past(owed_o)))));
endmodule

bind cbr_refresh_sched cbr_refresh_sched_chk #(
  .OWED_MAX (OWED_MAX),
  .FORCE_AT (FORCE_AT)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ref_gnt_i     (ref_gnt_i),
  .ref_req_o     (ref_req_o),
  .force_close_o (force_close_o),
  .bus_own_o     (bus_own_o),
  .init_done_o   (init_done_o),
  .host_ok_o     (host_ok_o),
  .owed_o        (owed_o),
  .ras_n_o       (ras_n_o),
  .cas_n_o       (cas_n_o),
  .we_n_o        (we_n_o)
);

// File: tb/cbr_refresh_sched_tb_top.sv
module cbr_refresh_sched_tb_top;
  localparam int PAUSE    = 20;
  localparam int INIT_N   = 8;
  localparam int INTERVAL = 30;
  localparam int OMAX     = 7;
  localparam int FORCE_AT = 4;
  localparam int CSR      = 1;
  localparam int CHR      = 2;
  localparam int RASC     = 8;
  localparam int RP       = 5;
  localparam int OW       = $clog2(OMAX + 1);

  // {intervals waited after first owed, expected owed, expected force}
  localparam int TBL [6][3] = '{
    '{0, 1, 0}, '{2, 3, 0}, '{3, 4, 1}, '{5, 6, 1}, '{6, 7, 1}, '{9, 7, 1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt = 1'b1;
  logic host_req = 1'b1;
  logic ref_req, force_close, bus_own, init_done, host_ok, ras_n, cas_n, we_n;
  logic [OW-1:0] owed;

  int n_chk = 0;
  int n_bad = 0;
  bit mon_on = 1'b0;
  int cbr_seen = 0;

  always #4 clk = ~clk;

  cbr_refresh_sched #(
    .PAUSE_CYC (PAUSE), .INIT_CBR (INIT_N), .INTERVAL_CYC (INTERVAL),
    .OWED_MAX (OMAX), .FORCE_AT (FORCE_AT),
    .CSR_CYC (CSR), .CHR_CYC (CHR), .RAS_CYC (RASC), .RP_CYC (RP)
  ) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .ref_gnt_i (gnt), .host_req_i (host_req),
    .ref_req_o (ref_req), .force_close_o (force_close), .bus_own_o (bus_own),
    .init_done_o (init_done), .host_ok_o (host_ok), .owed_o (owed),
    .ras_n_o (ras_n), .cas_n_o (cas_n), .we_n_o (we_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // CBR waveform monitor (R4, R5)
  bit prev_ras = 1'b1;
  int cas_pre = 0, ras_lo = 0, cas_lo_act = 0, ras_hi = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (prev_ras && !ras_n) begin
        chk(cas_pre == CSR, "R4 CAS setup cycles", cas_pre, CSR);
        chk(we_n == 1'b1, "R4 WE high at RAS fall", int'(we_n), 1);
        if (cbr_seen > 0)
          chk(ras_hi >= RP + CSR, "R5 RAS precharge cycles", ras_hi, RP + CSR);
        cbr_seen++;
        ras_lo = 1;
        cas_lo_act = cas_n ? 0 : 1;
      end else if (!ras_n) begin
        ras_lo++;
        if (!cas_n) cas_lo_act++;
      end
      if (!prev_ras && ras_n) begin
        chk(ras_lo == RASC, "R4 RAS low cycles", ras_lo, RASC);
        chk(cas_lo_act == CHR, "R4 CAS hold cycles", cas_lo_act, CHR);
        ras_hi = 1;
      end else if (ras_n) ras_hi++;
      if (ras_n && !cas_n) cas_pre++;
      else if (ras_n) cas_pre = 0;
      prev_ras = ras_n;
    end
  end

  task automatic drain();
    bit seen_own = 1'b0;
    int guard = 0;
    gnt = 1'b1;
    forever begin
      @(negedge clk);
      guard++;
      if (bus_own && !seen_own) begin
        seen_own = 1'b1;
        chk(host_ok == 1'b0, "R10 host refused during refresh", int'(host_ok), 0);
      end
      if ((owed == '0 && !bus_own) || guard > 2000) break;
    end
    chk(owed == '0, "R11 owed drained", int'(owed), 0);
    gnt = 1'b0;
  endtask

  initial begin
    int n;
    int bad_req;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 strobes high in reset", {ras_n, cas_n, we_n}, 7);
    chk(!init_done, "R1 init_done low", int'(init_done), 0);
    chk(!ref_req && !bus_own, "R1 no request", {ref_req, bus_own}, 0);
    chk(owed == '0, "R1 owed zero", int'(owed), 0);
    chk(!host_ok, "R1 host refused", int'(host_ok), 0);

    // R2 power-up pause
    rst_n = 1'b1;
    mon_on = 1'b1;
    n = 0;
    bad_req = 0;
    while (n < PAUSE + 50) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n < PAUSE && ref_req) bad_req++;
      if (!cas_n) break;
    end
    chk(bad_req == 0, "R2 no request during pause", bad_req, 0);
    chk(n == PAUSE + 1, "R2 first CAS fall edge", n, PAUSE + 1);
    chk(!host_ok, "R10 host refused before init", int'(host_ok), 0);

    // R3 init refresh count
    @(posedge init_done);
    chk(cbr_seen == INIT_N, "R3 init CBR count", cbr_seen, INIT_N);
    @(negedge clk);
    gnt = 1'b0;
    chk(owed == '0 && !force_close, "R8 no force at zero owed", int'(force_close), 0);
    chk(host_ok == 1'b1, "R10 host accepted when idle", int'(host_ok), 1);

    // R6 exact interval
    @(posedge ref_req);
    repeat (INTERVAL - 1) @(posedge clk);
    @(negedge clk);
    chk(owed == OW'(1), "R6 owed before second tick", int'(owed), 1);
    chk(ras_n && cas_n && !bus_own, "R9 strobes idle without grant", {ras_n, cas_n, bus_own}, 6);
    @(posedge clk);
    @(negedge clk);
    chk(owed == OW'(2), "R6 owed at second tick", int'(owed), 2);
    chk(init_done, "R3 init_done stays high", int'(init_done), 1);
    drain();

    // table of hold lengths: R6, R7, R8
    for (int i = 0; i < 6; i++) begin
      @(posedge ref_req);
      repeat (TBL[i][0] * INTERVAL) @(posedge clk);
      @(negedge clk);
      chk(int'(owed) == TBL[i][1], "R7 owed after hold", int'(owed), TBL[i][1]);
      chk(int'(force_close) == TBL[i][2], "R8 force_close level", int'(force_close), TBL[i][2]);
      chk(ras_n && cas_n, "R9 no strobes while grant low", {ras_n, cas_n}, 3);
      drain();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule